// File: doc/BRIEF.md
# Parity Fault Injection Controller

This block is an eight-bit control register that lets self-test software plant single, deliberate faults in a processor's parity checking and lockstep comparison. Each fault is armed by writing a 1 to its inject bit. The armed bit waits for the next transaction of its own kind and raises a flip-parity output for that transaction's bus field while the transaction is valid. When that transaction completes, the bit clears itself. Software can then confirm that the checker downstream reports the error.

Data-bus faults apply only to the main data bus. Accesses inside the low single-cycle I/O address window are skipped: they receive no fault and do not consume the armed bit. The register also holds a bit that keeps injected errors from reaching the non-maskable interrupt, and a sticky lock that blocks further writes to the stack-limit register. A register write lands only while the configuration-change protection gate is open.

Top module: `fault_inject_ctrl`

## Requirements
- R1: After synchronous reset all eight register bits are 0, every flip output and `force_cmp_miss` are low, and `nmi_en` is high.
- R2: A write with `wr_en` high and `cfg_unlocked` high loads `wr_data` at the clock edge. `rd_data` shows the register with this layout: bit 7 NMI suppress, bit 6 comparator inject, bit 5 data-bus data inject, bit 4 data-bus address inject, bit 3 data-bus control inject, bit 2 instruction-bus address inject, bit 1 instruction-bus control inject, bit 0 stack-limit lock.
- R3: A write while `cfg_unlocked` is low leaves the register unchanged.
- R4: While bit 2 or bit 1 is armed, `flip_ia` or `flip_ic` (respectively) follows `ifetch_vld`. The bit clears at the edge where `ifetch_done` is high.
- R5: While bit 4 or bit 3 is armed, `flip_da` or `flip_dc` (respectively) is high during any main-bus data access, read or write. The bit clears when that access's `dacc_done` is seen.
- R6: Bit 5 drives `flip_dd` only during main-bus write accesses (`dacc_write` = 1). A read access neither flips nor clears it.
- R7: A data access whose address is below 64 raises no data-bus flip output and clears no data-bus inject bit. Address 64 is the first address that qualifies.
- R8: While bit 6 is armed, `force_cmp_miss` is high in the cycle `instr_retire` is high. Bit 6 clears at that edge.
- R9: `nmi_en` is the inverse of bit 7.
- R10: Once set, bit 0 stays 1 until reset, even if software writes 0 to it. While bit 0 is 1, `splim_wr_grant` stays low whatever the value of `splim_wr_req`. While bit 0 is 0, `splim_wr_grant` equals `splim_wr_req`.
- R11: A write and a completing qualifying transaction may fall in the same cycle. In that case an inject bit that was already armed is cleared. A bit that was not armed and is written to 1 becomes armed for a later transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_unlocked | input | 1 | Configuration-change protection gate is open |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| rd_data | output | 8 | Current register value |
| ifetch_vld | input | 1 | Instruction fetch valid phase |
| ifetch_done | input | 1 | Instruction fetch completes this cycle |
| dacc_vld | input | 1 | Data access valid phase |
| dacc_done | input | 1 | Data access completes this cycle |
| dacc_write | input | 1 | Data access is a write |
| dacc_addr | input | ADDR_W | Data access address |
| instr_retire | input | 1 | One instruction completes this cycle |
| splim_wr_req | input | 1 | Request to write the stack-limit register |
| flip_ia | output | 1 | Invert instruction-bus address parity |
| flip_ic | output | 1 | Invert instruction-bus control parity |
| flip_da | output | 1 | Invert data-bus address parity |
| flip_dc | output | 1 | Invert data-bus control parity |
| flip_dd | output | 1 | Invert data-bus write data parity |
| force_cmp_miss | output | 1 | Force one lockstep compare mismatch |
| nmi_en | output | 1 | Injected errors may raise an NMI |
| splim_wr_grant | output | 1 | Stack-limit write permitted |

## Verification
The bench probes the I/O window edge at addresses 63 and 64. A design with an off-by-one comparison would either corrupt an I/O access or let a main-bus access slip by. It sends a read to an armed data-bus data inject, which a design ignoring direction would flip and consume. It checks a valid phase without completion, where a design clearing on valid rather than done would lose the fault early. It also writes the lock bit back to 0, which a non-sticky design would obey. Finally, it rewrites armed bits in the same cycle as their completing access. A design giving the write priority there would keep the bits armed and inject a second fault.

// File: rtl/fic_pkg.sv
// Package: shared field positions of the fault injection control register.
// Assumes: an eight-bit register; bit positions are software-visible layout.
package fic_pkg;
    localparam int CTL_W      = 8;
    localparam int B_SPLOCK   = 0;
    localparam int B_IBUS_CTL = 1;
    localparam int B_IBUS_ADR = 2;
    localparam int B_DBUS_CTL = 3;
    localparam int B_DBUS_ADR = 4;
    localparam int B_DBUS_DAT = 5;
    localparam int B_CMP      = 6;
    localparam int B_NMI_OFF  = 7;
    localparam int INJ_LO     = B_IBUS_CTL;
    localparam int INJ_HI     = B_CMP;
endpackage

// File: rtl/fic_addr_qual.sv
// Module: decides whether a data access targets the main bus, i.e. lies at
// or above the single-cycle I/O window.
// Assumes: the I/O window starts at address 0 and spans IO_WIN locations.
module fic_addr_qual #(
    parameter int ADDR_W = 16,
    parameter int IO_WIN = 64
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              main_bus
);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(IO_WIN);

    // Compare the address against the window bound.
    always_comb main_bus = (addr >= WIN_END);
endmodule

// File: rtl/fic_oneshot.sv
// Module: a single one-shot inject bit. Software arms or disarms it; a
// qualifying completion clears it, and that clear wins over a same-cycle write.
// Assumes: evt is a single-cycle completion strobe already qualified.
module fic_oneshot (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_val,
    input  logic evt,
    output logic armed
);
    logic consume;

    // A completion consumes the bit only if it was armed before this edge.
    always_comb consume = armed && evt;

    // Register update with completion-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)       armed <= 1'b0;
        else if (consume) armed <= 1'b0;
        else if (wr_stb)  armed <= wr_val;
    end

    a_r11_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && evt) |=> !armed);
    a_r4_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !evt && !wr_stb) |=> armed);
endmodule

// File: rtl/fault_inject_ctrl.sv
// Module: top of the parity fault injection controller. Holds the control
// register, gates writes with configuration-change protection, qualifies
// bus transactions and drives per-field flip-parity outputs.
// Assumes: *_done strobes occur only inside their *_vld phase; address and
// direction are stable while dacc_vld is high.
module fault_inject_ctrl
    import fic_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int IO_WIN = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_unlocked,
    input  logic              wr_en,
    input  logic [CTL_W-1:0]  wr_data,
    output logic [CTL_W-1:0]  rd_data,
    input  logic              ifetch_vld,
    input  logic              ifetch_done,
    input  logic              dacc_vld,
    input  logic              dacc_done,
    input  logic              dacc_write,
    input  logic [ADDR_W-1:0] dacc_addr,
    input  logic              instr_retire,
    input  logic              splim_wr_req,
    output logic              flip_ia,
    output logic              flip_ic,
    output logic              flip_da,
    output logic              flip_dc,
    output logic              flip_dd,
    output logic              force_cmp_miss,
    output logic              nmi_en,
    output logic              splim_wr_grant
);
    logic                 wr_ok;
    logic                 main_bus;
    logic                 lock_q;
    logic                 nmi_off_q;
    logic [INJ_HI:INJ_LO] evt;
    logic [INJ_HI:INJ_LO] armed;
    logic [CTL_W-1:0]     ctl_q;

    // Protection gate on software writes.
    always_comb wr_ok = wr_en && cfg_unlocked;

    fic_addr_qual #(.ADDR_W(ADDR_W), .IO_WIN(IO_WIN)) u_qual (
        .addr     (dacc_addr),
        .main_bus (main_bus)
    );

    // Completion events, one per inject bit.
    always_comb begin
        evt[B_IBUS_CTL] = ifetch_done;
        evt[B_IBUS_ADR] = ifetch_done;
        evt[B_DBUS_CTL] = dacc_done && main_bus;
        evt[B_DBUS_ADR] = dacc_done && main_bus;
        evt[B_DBUS_DAT] = dacc_done && main_bus && dacc_write;
        evt[B_CMP]      = instr_retire;
    end

    for (genvar gi = INJ_LO; gi <= INJ_HI; gi++) begin : g_inj
        fic_oneshot u_bit (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_stb (wr_ok),
            .wr_val (wr_data[gi]),
            .evt    (evt[gi]),
            .armed  (armed[gi])
        );
    end

    // NMI suppress bit: plain read/write storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     nmi_off_q <= 1'b0;
        else if (wr_ok) nmi_off_q <= wr_data[B_NMI_OFF];
    end

    // Stack-limit lock: set-only until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                          lock_q <= 1'b0;
        else if (wr_ok && wr_data[B_SPLOCK]) lock_q <= 1'b1;
    end

    // Register image for readback.
    always_comb begin
        ctl_q                 = '0;
        ctl_q[B_SPLOCK]       = lock_q;
        ctl_q[B_NMI_OFF]      = nmi_off_q;
        ctl_q[INJ_HI:INJ_LO]  = armed;
    end
    assign rd_data = ctl_q;

    // Flip outputs during the valid phase of a qualifying transaction.
    always_comb begin
        flip_ic        = armed[B_IBUS_CTL] && ifetch_vld;
        flip_ia        = armed[B_IBUS_ADR] && ifetch_vld;
        flip_dc        = armed[B_DBUS_CTL] && dacc_vld && main_bus;
        flip_da        = armed[B_DBUS_ADR] && dacc_vld && main_bus;
        flip_dd        = armed[B_DBUS_DAT] && dacc_vld && main_bus && dacc_write;
        force_cmp_miss = armed[B_CMP] && instr_retire;
        nmi_en         = !nmi_off_q;
        splim_wr_grant = splim_wr_req && !lock_q;
    end

    a_r3_protect: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && cfg_unlocked) |=> ((ctl_q & ~$past(ctl_q)) == '0));
    a_r7_io_window: assert property (@(posedge clk) disable iff (!rst_n)
        (dacc_vld && dacc_addr < ADDR_W'(IO_WIN)) |-> !(flip_da || flip_dc || flip_dd));
    a_r6_dd_write_only: assert property (@(posedge clk) disable iff (!rst_n)
        flip_dd |-> dacc_write);
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |=> lock_q);
    a_r10_grant_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        lock_q |-> !splim_wr_grant);
endmodule

// File: tb/sim_fault_inject_ctrl.sv
`timescale 1ns/100ps
module sim_fault_inject_ctrl;
    localparam int ADDR_W = 16;

    typedef struct packed {
        logic [3:0]        req;
        logic              unlk;
        logic              wr;
        logic [7:0]        wd;
        logic              fv;
        logic              fd;
        logic              dv;
        logic              dd;
        logic              dw;
        logic [ADDR_W-1:0] addr;
        logic              ret;
        logic              sreq;
        logic [7:0]        exp_o;  // {ia,ic,da,dc,dd,cmp,nmi_en,grant}
        logic [7:0]        exp_rd; // register after the edge
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{4'd3,  1'b0,1'b1,8'h7E, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1, 8'h03, 8'h00}, // R3
        '{4'd2,  1'b1,1'b1,8'h7E, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 8'h02, 8'h7E}, // R2
        '{4'd7,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1,1'b0,16'h0020, 1'b0,1'b0, 8'h02, 8'h7E}, // R7
        '{4'd7,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1,1'b1,16'h003F, 1'b0,1'b0, 8'h02, 8'h7E}, // R7
        '{4'd5,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1,1'b0,16'h0040, 1'b0,1'b0, 8'h32, 8'h66}, // R5 R6
        '{4'd6,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b0,1'b1,16'h1000, 1'b0,1'b0, 8'h0A, 8'h66}, // R6
        '{4'd6,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b1,1'b1,1'b1,16'h1000, 1'b0,1'b0, 8'h0A, 8'h46}, // R6
        '{4'd4,  1'b0,1'b0,8'h00, 1'b1,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 8'hC2, 8'h46}, // R4
        '{4'd4,  1'b0,1'b0,8'h00, 1'b1,1'b1, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 8'hC2, 8'h40}, // R4
        '{4'd8,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0, 8'h06, 8'h00}, // R8
        '{4'd8,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b1,1'b0, 8'h02, 8'h00}, // R8
        '{4'd10, 1'b1,1'b1,8'h81, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1, 8'h03, 8'h81}, // R10
        '{4'd9,  1'b0,1'b0,8'h00, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b1, 8'h00, 8'h81}, // R9 R10
        '{4'd10, 1'b1,1'b1,8'h00, 1'b0,1'b0, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 8'h00, 8'h01}, // R10
        '{4'd11, 1'b1,1'b1,8'h3E, 1'b1,1'b1, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 8'h02, 8'h3F}, // R11
        '{4'd11, 1'b1,1'b1,8'h3E, 1'b0,1'b0, 1'b1,1'b1,1'b1,16'h0100, 1'b0,1'b0, 8'h3A, 8'h07}, // R11
        '{4'd4,  1'b0,1'b0,8'h00, 1'b1,1'b1, 1'b0,1'b0,1'b0,16'h0000, 1'b0,1'b0, 8'hC2, 8'h01}  // R4
    };

    logic clk = 1'b0;
    logic rst_n;
    logic cfg_unlocked, wr_en, ifetch_vld, ifetch_done, dacc_vld, dacc_done;
    logic dacc_write, instr_retire, splim_wr_req;
    logic [7:0] wr_data, rd_data;
    logic [ADDR_W-1:0] dacc_addr;
    logic flip_ia, flip_ic, flip_da, flip_dc, flip_dd, force_cmp_miss, nmi_en, splim_wr_grant;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    fault_inject_ctrl #(.ADDR_W(ADDR_W), .IO_WIN(64)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_unlocked(cfg_unlocked), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .ifetch_vld(ifetch_vld),
        .ifetch_done(ifetch_done), .dacc_vld(dacc_vld), .dacc_done(dacc_done),
        .dacc_write(dacc_write), .dacc_addr(dacc_addr), .instr_retire(instr_retire),
        .splim_wr_req(splim_wr_req), .flip_ia(flip_ia), .flip_ic(flip_ic),
        .flip_da(flip_da), .flip_dc(flip_dc), .flip_dd(flip_dd),
        .force_cmp_miss(force_cmp_miss), .nmi_en(nmi_en), .splim_wr_grant(splim_wr_grant)
    );

    function automatic logic [7:0] outs();
        return {flip_ia, flip_ic, flip_da, flip_dc, flip_dd, force_cmp_miss, nmi_en, splim_wr_grant};
    endfunction

    task automatic check(input int req, input string what, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cfg_unlocked = 0; wr_en = 0; wr_data = 0; ifetch_vld = 0; ifetch_done = 0;
        dacc_vld = 0; dacc_done = 0; dacc_write = 0; dacc_addr = 0;
        instr_retire = 0; splim_wr_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); idle(); rst_n = 0;
        @(negedge clk); @(negedge clk); rst_n = 1;
    endtask

    initial begin
        idle();
        rst_n = 0;
        do_reset();
        #1;
        check(1, "reset register", rd_data, 8'h00);   // R1
        check(1, "reset outputs", outs(), 8'h02);    // R1
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            cfg_unlocked = VECS[i].unlk; wr_en = VECS[i].wr; wr_data = VECS[i].wd;
            ifetch_vld = VECS[i].fv; ifetch_done = VECS[i].fd;
            dacc_vld = VECS[i].dv; dacc_done = VECS[i].dd; dacc_write = VECS[i].dw;
            dacc_addr = VECS[i].addr; instr_retire = VECS[i].ret; splim_wr_req = VECS[i].sreq;
            #1;
            check(int'(VECS[i].req), $sformatf("vec %0d outputs", i), outs(), VECS[i].exp_o);
            @(posedge clk); #1;
            check(int'(VECS[i].req), $sformatf("vec %0d register", i), rd_data, VECS[i].exp_rd);
        end
        // Directed: reset clears a sticky lock and armed bits (R1, R10).
        @(negedge clk); idle(); cfg_unlocked = 1; wr_en = 1; wr_data = 8'hFF;
        do_reset(); #1;
        check(1, "reset after full write", rd_data, 8'h00);  // R1
        check(10, "grant free after reset", splim_wr_grant, 1'b0); // no request: low
        @(negedge clk); splim_wr_req = 1; #1;
        check(10, "grant follows request when unlocked", splim_wr_grant, 1'b1); // R10
        // Directed: armed data-bus data inject is not consumed by a main read (R6).
        @(negedge clk); idle(); cfg_unlocked = 1; wr_en = 1; wr_data = 8'h20;
        @(negedge clk); idle(); dacc_vld = 1; dacc_done = 1; dacc_addr = 16'h0200; #1;
        check(6, "read does not flip data", flip_dd, 1'b0);
        @(negedge clk); idle(); #1;
        check(6, "read does not consume data inject", rd_data, 8'h20);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R1 watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule